// File: doc/BRIEF.md
# Converter Power and Calibration Sequencer

This block is the control state machine that brings a mixed-signal converter out of power-down and keeps it in a calibrated, running state. It has four states: power-down, low-power reset, active and stand-by. An active-low power-down pin forces the register file to its defaults. A register-held reset bit keeps the converters and the reference-current source off while software loads its settings. Clearing that bit powers the converters up and starts an offset calibration. That calibration is modelled as a busy interval of a set number of cycles on the free-running reference clock.

While the block is active, a calibration also starts when a clock selection field changes, when the PLL regains lock, or when software raises its calibration request from 0 to 1. A request that arrives during a calibration reloads the timer. A second calibration is never queued. The block also watches the master clock and the frame clock. If the master clock stops, or the frame clock drifts out of ratio, the block falls back to stand-by and keeps the register contents. Once both clocks are healthy again, it passes through reset exit, which runs a fresh calibration.

The master clock and the frame clock arrive as single-cycle activity pulses on the reference clock. Each pulse marks one master-clock edge or one frame start.

Top module: `codec_pwr_seq`

## Requirements
- R1: One cycle after `pdn_n` is sampled low, `regs_rst` is 1 and `conv_en`, `vref_en` and `cal_busy` are 0. This holds for as long as `pdn_n` stays low.
- R2: Once `pdn_n` is high, `regs_rst` is 0. While `rst_bit` is 1, `conv_en` and `vref_en` stay 0 and no calibration runs.
- R3: When `rst_bit` is 0 in low-power reset and the clocks are valid, the next cycle has `conv_en` and `vref_en` at 1 and `cal_busy` at 1. `cal_busy` then stays 1 for exactly CAL_CYCLES cycles.
- R4: While active, any change of `clk_src_sel` or `clk_in_sel` starts a calibration (`cal_busy` is 1 from the next cycle).
- R5: While active, a 0-to-1 transition of `pll_lock` starts a calibration.
- R6: A software calibration starts only on a 0-to-1 transition of `cal_req`. Holding `cal_req` at 1 starts no further calibration.
- R7: A calibration start while `cal_busy` is 1 reloads the timer. `cal_busy` then ends exactly CAL_CYCLES cycles after the latest start.
- R8: If no `mclk_tick` pulse arrives for LOSS_CYCLES consecutive cycles while active, the block enters stand-by. In stand-by `conv_en`, `vref_en` and `cal_busy` are 0 and `regs_rst` stays 0.
- R9: At each `lrck_tick`, the count of `mclk_tick` pulses since the previous `lrck_tick` is compared with FRAME_RATIO. A pulse that coincides with `lrck_tick` counts toward the new frame. Two consecutive mismatching periods put the active block into stand-by. A single mismatch does not.
- R10: When the clocks are valid again, stand-by returns through low-power reset. With `rst_bit` at 0, the block re-enters active one cycle later with a new calibration.
- R11: Setting `rst_bit` to 1 while active returns the block to low-power reset, clears `conv_en` and `vref_en`, and aborts any calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pdn_n | input | 1 | Power-down pin, active low |
| rst_bit | input | 1 | Register-held low-power reset bit |
| cal_req | input | 1 | Software calibration request bit (rising edge acts) |
| clk_src_sel | input | SRC_W | Clock-source select field |
| clk_in_sel | input | 1 | Clock-input select field |
| pll_lock | input | 1 | PLL lock indicator |
| mclk_tick | input | 1 | One pulse per master-clock edge, synchronous to `clk` |
| lrck_tick | input | 1 | One pulse per frame-clock period start, synchronous to `clk` |
| cal_busy | output | 1 | Calibration in progress |
| conv_en | output | 1 | Converter power enable |
| vref_en | output | 1 | Common-mode reference-current enable |
| regs_rst | output | 1 | Forces the control registers to their defaults |

## Verification
The embedded properties assume that `mclk_tick` and `lrck_tick` are already synchronous, single-cycle pulses on the reference clock. They also assume that the register inputs only change between clock edges and that reset is held for the first cycles. The bench drives every input on the falling edge. It generates both tick streams from one phase counter, so the frame ratio is set exactly by a chosen frame length. It shortens the calibration and loss windows so that every state transition occurs within a few dozen cycles.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;

    typedef enum logic [1:0] {
        PS_OFF  = 2'd0,   // pin power-down, registers held at defaults
        PS_HOLD = 2'd1,   // low-power reset, register port live
        PS_RUN  = 2'd2,   // converters powered
        PS_IDLE = 2'd3    // stand-by after clock fault
    } pwr_state_e;

    typedef struct packed {
        logic start;
        logic abort;
    } cal_cmd_t;

    typedef struct packed {
        logic sw_edge;
        logic cfg_change;
        logic relock;
    } cal_src_t;

    function automatic logic any_src(input cal_src_t s);
        return s.sw_edge | s.cfg_change | s.relock;
    endfunction

    function automatic logic drives_analog(input pwr_state_e s);
        return s == PS_RUN;
    endfunction

endpackage

// File: rtl/codec_clk_monitor.sv
module codec_clk_monitor #(
    parameter int LOSS_CYCLES = 246,
    parameter int FRAME_RATIO = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic mclk_tick,
    input  logic lrck_tick,
    output logic clk_bad
);
    localparam int GW = $clog2(LOSS_CYCLES + 1);
    localparam int MW = $clog2(2 * FRAME_RATIO + 1);
    localparam logic [GW-1:0] GAP_LIM   = GW'(LOSS_CYCLES);
    localparam logic [MW-1:0] RATIO_L   = MW'(FRAME_RATIO);
    localparam logic [MW-1:0] MCNT_MAX  = {MW{1'b1}};

    logic [GW-1:0] gap_q;
    logic [MW-1:0] mcnt_q;
    logic [1:0]    miss_q;
    logic          mclk_lost;
    logic          frame_async;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
        end else if (mclk_tick) begin
            gap_q <= '0;
        end else if (gap_q != GAP_LIM) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcnt_q <= '0;
            miss_q <= '0;
        end else if (lrck_tick) begin
            mcnt_q <= MW'(mclk_tick);
            if (mcnt_q != RATIO_L)
                miss_q <= (miss_q == 2'd2) ? 2'd2 : miss_q + 2'd1;
            else
                miss_q <= 2'd0;
        end else if (mclk_tick && mcnt_q != MCNT_MAX) begin
            mcnt_q <= mcnt_q + 1'b1;
        end
    end

    assign mclk_lost   = (gap_q == GAP_LIM);
    assign frame_async = (miss_q == 2'd2);
    assign clk_bad     = mclk_lost | frame_async;

    // R8
    mclk_revive_chk: assert property (@(posedge clk) disable iff (rst)
        mclk_tick |=> !mclk_lost);

    // R9
    async_on_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_async) |-> $past(lrck_tick));

endmodule

// File: rtl/codec_cal_trigger.sv
module codec_cal_trigger
    import codec_pwr_pkg::*;
#(
    parameter int SRC_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cal_req,
    input  logic [SRC_W-1:0] clk_src_sel,
    input  logic             clk_in_sel,
    input  logic             pll_lock,
    output logic             trig
);
    logic             req_q;
    logic [SRC_W-1:0] src_q;
    logic             insel_q;
    logic             lock_q;
    cal_src_t         src;

    // history registers track inputs every cycle, reset included
    always_ff @(posedge clk) begin
        req_q   <= cal_req;
        src_q   <= clk_src_sel;
        insel_q <= clk_in_sel;
        lock_q  <= pll_lock;
    end

    always_comb begin
        src.sw_edge    = cal_req & ~req_q;
        src.cfg_change = (clk_src_sel != src_q) | (clk_in_sel != insel_q);
        src.relock     = pll_lock & ~lock_q;
        trig           = any_src(src);
    end

    // R6
    level_req_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cal_req && $past(cal_req) && $stable(clk_src_sel) && $stable(clk_in_sel)
         && !$rose(pll_lock)) |-> !trig);

endmodule

// File: rtl/codec_cal_timer.sv
module codec_cal_timer
    import codec_pwr_pkg::*;
#(
    parameter int CAL_CYCLES = 1228800
) (
    input  logic     clk,
    input  logic     rst,
    input  cal_cmd_t cmd,
    output logic     busy
);
    localparam int CW = $clog2(CAL_CYCLES + 1);
    localparam logic [CW-1:0] CAL_LOAD = CW'(CAL_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || cmd.abort) begin
            cnt_q <= '0;
        end else if (cmd.start) begin
            cnt_q <= CAL_LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

    // R7
    restart_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.start && !cmd.abort) |=> (busy && cnt_q == CAL_LOAD));

    // R3
    countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !cmd.start && !cmd.abort) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
    import codec_pwr_pkg::*;
#(
    parameter int SRC_W       = 2,
    parameter int CAL_CYCLES  = 1228800,
    parameter int LOSS_CYCLES = 246,
    parameter int FRAME_RATIO = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pdn_n,
    input  logic             rst_bit,
    input  logic             cal_req,
    input  logic [SRC_W-1:0] clk_src_sel,
    input  logic             clk_in_sel,
    input  logic             pll_lock,
    input  logic             mclk_tick,
    input  logic             lrck_tick,
    output logic             cal_busy,
    output logic             conv_en,
    output logic             vref_en,
    output logic             regs_rst
);
    pwr_state_e st_q, st_d;
    cal_cmd_t   cmd;
    logic       clk_bad;
    logic       trig;

    codec_clk_monitor #(
        .LOSS_CYCLES (LOSS_CYCLES),
        .FRAME_RATIO (FRAME_RATIO)
    ) u_mon (
        .clk       (clk),
        .rst       (rst),
        .mclk_tick (mclk_tick),
        .lrck_tick (lrck_tick),
        .clk_bad   (clk_bad)
    );

    codec_cal_trigger #(
        .SRC_W (SRC_W)
    ) u_trig (
        .clk         (clk),
        .rst         (rst),
        .cal_req     (cal_req),
        .clk_src_sel (clk_src_sel),
        .clk_in_sel  (clk_in_sel),
        .pll_lock    (pll_lock),
        .trig        (trig)
    );

    codec_cal_timer #(
        .CAL_CYCLES (CAL_CYCLES)
    ) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .busy (cal_busy)
    );

    always_comb begin
        st_d      = st_q;
        cmd.start = 1'b0;
        cmd.abort = 1'b0;
        if (!pdn_n) begin
            st_d      = PS_OFF;
            cmd.abort = 1'b1;
        end else begin
            unique case (st_q)
                PS_OFF:  st_d = PS_HOLD;
                PS_HOLD: begin
                    if (!rst_bit) begin
                        if (clk_bad) begin
                            st_d = PS_IDLE;
                        end else begin
                            st_d      = PS_RUN;
                            cmd.start = 1'b1;
                        end
                    end
                end
                PS_RUN: begin
                    if (rst_bit) begin
                        st_d      = PS_HOLD;
                        cmd.abort = 1'b1;
                    end else if (clk_bad) begin
                        st_d      = PS_IDLE;
                        cmd.abort = 1'b1;
                    end else if (trig) begin
                        cmd.start = 1'b1;
                    end
                end
                PS_IDLE: begin
                    if (rst_bit || !clk_bad) st_d = PS_HOLD;
                end
                default: st_d = PS_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= PS_OFF;
        else     st_q <= st_d;
    end

    assign conv_en  = drives_analog(st_q);
    assign vref_en  = drives_analog(st_q);
    assign regs_rst = (st_q == PS_OFF);

    // R1
    pdn_forces_off_chk: assert property (@(posedge clk) disable iff (rst)
        !pdn_n |=> (regs_rst && !conv_en && !vref_en && !cal_busy));

    // R2
    hold_keeps_off_chk: assert property (@(posedge clk) disable iff (rst)
        (pdn_n && rst_bit && $past(pdn_n)) |=> (!regs_rst && !conv_en && !vref_en));

    // R3
    exit_calibrates_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_HOLD && pdn_n && !rst_bit && !clk_bad) |=> (conv_en && cal_busy));

    // R8
    fault_to_standby_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_en && pdn_n && !rst_bit && clk_bad) |=> (!conv_en && !cal_busy && !regs_rst));

    // R11
    reset_bit_aborts_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_en && pdn_n && rst_bit) |=> (!conv_en && !vref_en && !cal_busy));

endmodule

// File: tb/sim_codec_pwr_seq.sv
module sim_codec_pwr_seq;
    localparam int SRC_W = 2;
    localparam int CAL   = 20;
    localparam int LOSS  = 8;
    localparam int RATIO = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pdn_n = 1'b0, rst_bit = 1'b1, cal_req = 1'b0;
    logic [SRC_W-1:0] clk_src_sel = '0;
    logic clk_in_sel = 1'b0, pll_lock = 1'b1;
    logic mclk_tick = 1'b0, lrck_tick = 1'b0;
    logic cal_busy, conv_en, vref_en, regs_rst;

    always #5 clk = ~clk;

    codec_pwr_seq #(
        .SRC_W(SRC_W), .CAL_CYCLES(CAL), .LOSS_CYCLES(LOSS), .FRAME_RATIO(RATIO)
    ) u0 (
        .clk(clk), .rst(rst), .pdn_n(pdn_n), .rst_bit(rst_bit), .cal_req(cal_req),
        .clk_src_sel(clk_src_sel), .clk_in_sel(clk_in_sel), .pll_lock(pll_lock),
        .mclk_tick(mclk_tick), .lrck_tick(lrck_tick),
        .cal_busy(cal_busy), .conv_en(conv_en), .vref_en(vref_en), .regs_rst(regs_rst)
    );

    // tick generator: phase counter, master ticks on even phases
    int  phase = 0;
    int  frame_len = 8;
    bit  mclk_run = 1'b1;
    always @(negedge clk) begin
        mclk_tick <= mclk_run && (phase % 2 == 0);
        lrck_tick <= (phase == 0);
        phase     <= (phase + 1 >= frame_len) ? 0 : phase + 1;
    end

    // behavioural reference model: 0 off, 1 hold, 2 run, 3 standby
    int  m_state, m_timer, m_gap, m_ticks, m_bad_frames;
    bit  h_req, h_lock, h_in;
    int  h_src;
    bit  started = 1'b0;
    int  cycles = 0;
    int  vectors = 0, errors = 0;
    string cur_req = "R1";

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        bit fault, kick, go, stop;
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            finish_run();
        end
        fault = (m_gap >= LOSS) || (m_bad_frames >= 2);
        kick  = (cal_req && !h_req) || (int'(clk_src_sel) != h_src) ||
                (clk_in_sel != h_in) || (pll_lock && !h_lock);
        go = 0; stop = 0;
        if (rst) begin
            m_state = 0; m_timer = 0; m_gap = 0; m_ticks = 0; m_bad_frames = 0;
        end else begin
            if (!pdn_n) begin m_state = 0; stop = 1; end
            else if (m_state == 0) m_state = 1;
            else if (m_state == 1) begin
                if (!rst_bit) begin
                    if (fault) m_state = 3; else begin m_state = 2; go = 1; end
                end
            end else if (m_state == 2) begin
                if (rst_bit) begin m_state = 1; stop = 1; end
                else if (fault) begin m_state = 3; stop = 1; end
                else if (kick) go = 1;
            end else begin
                if (rst_bit || !fault) m_state = 1;
            end
            if (stop) m_timer = 0;
            else if (go) m_timer = CAL;
            else if (m_timer > 0) m_timer--;
            m_gap = mclk_tick ? 0 : ((m_gap < LOSS) ? m_gap + 1 : m_gap);
            if (lrck_tick) begin
                m_bad_frames = (m_ticks != RATIO) ? ((m_bad_frames < 2) ? m_bad_frames + 1 : 2) : 0;
                m_ticks = mclk_tick ? 1 : 0;
            end else if (mclk_tick) m_ticks++;
        end
        h_req = cal_req; h_lock = pll_lock; h_in = clk_in_sel; h_src = int'(clk_src_sel);
        started = 1'b1;
    end

    always @(negedge clk) begin
        logic [3:0] got, exp;
        if (started) begin
            got = {regs_rst, conv_en, vref_en, cal_busy};
            exp = {m_state == 0, m_state == 2, m_state == 2, m_timer != 0};
            vectors++;
            if (got !== exp) begin
                errors++;
                $display("FAIL %s: {regs_rst,conv_en,vref_en,cal_busy} actual %b expected %b",
                         cur_req, got, exp);
            end
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        wait_n(4);
        rst = 1'b0;
        cur_req = "R1";  wait_n(6);
        cur_req = "R2";  pdn_n = 1'b1; wait_n(10);
        cur_req = "R3";  rst_bit = 1'b0; wait_n(30);
        cur_req = "R6";  cal_req = 1'b1; wait_n(30);
        cal_req = 1'b0;  wait_n(4);
        cal_req = 1'b1;  wait_n(8);
        cur_req = "R7";  cal_req = 1'b0; wait_n(2);
        cal_req = 1'b1;  wait_n(30);
        cal_req = 1'b0;
        cur_req = "R4";  clk_src_sel = 2'd2; wait_n(30);
        clk_in_sel = 1'b1; wait_n(30);
        cur_req = "R5";  pll_lock = 1'b0; wait_n(5);
        pll_lock = 1'b1; wait_n(30);
        cur_req = "R8";  mclk_run = 1'b0; wait_n(16);
        cur_req = "R10"; mclk_run = 1'b1; wait_n(45);
        cur_req = "R9";  frame_len = 6; wait_n(30);
        cur_req = "R10"; frame_len = 8; wait_n(45);
        cur_req = "R11"; cal_req = 1'b1; wait_n(5);
        rst_bit = 1'b1; cal_req = 1'b0; wait_n(10);
        rst_bit = 1'b0; wait_n(30);
        cur_req = "R1";  pdn_n = 1'b0; rst_bit = 1'b1; wait_n(6);
        cur_req = "R2";  pdn_n = 1'b1; wait_n(6);
        finish_run();
    end
endmodule